// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards a transceiver's transmit driver against a station that never stops sending. It samples a transmit-activity flag from the transmit squelch path on every edge of a free-running timebase, nominally 10 MHz. A continuous burst longer than the legal maximum trips a fault. The fault blocks the transmit driver and raises a request to the collision signalling logic. That request stays up for as long as the offending activity continues.

When the activity stops, the collision request drops but the driver stays blocked. The block then waits through a long recovery window in which the transmit input must stay quiet. Any activity inside that window starts the wait again from zero.

Both the activation length and the recovery length are parameters. The defaults are 200,000 cycles (20 ms) and 5,000,000 cycles (500 ms) at 10 MHz. A bench can shorten both and probe each boundary cycle by cycle.

There are three states:
- WATCH: the driver is enabled and the burst length is counted.
- TRIPPED: the fault is present, the driver is blocked and collision is requested.
- QUIET: the block is waiting out the recovery window with the driver blocked.

The transitions are:
- WATCH to TRIPPED: a burst reaches the activation length.
- TRIPPED to QUIET: the first inactive sample arrives.
- QUIET to QUIET: activity seen during recovery restarts the window.
- QUIET to WATCH: the recovery window completes.

Top module: `jab_watchdog`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the block returns to WATCH. After that edge, `tx_enable_o`=1, `jabber_o`=0 and `coll_req_o`=0.
- R2: In WATCH, `tx_active_i` may be sampled high at ACT_CYCLES consecutive rising edges. Right after the last of those edges, `tx_enable_o`=0, `jabber_o`=1 and `coll_req_o`=1 (state TRIPPED).
- R3: A burst of only ACT_CYCLES-1 consecutive high samples that is followed by a low sample leaves `tx_enable_o`=1 and `jabber_o`=0.
- R4: A single low sample in WATCH clears the burst count. Two bursts of ACT_CYCLES-1 high samples separated by one low sample do not trip.
- R5: In TRIPPED, `coll_req_o` stays 1 for as long as `tx_active_i` stays high.
- R6: The first low sample of `tx_active_i` in TRIPPED moves the block to QUIET. After that edge, `coll_req_o`=0, `jabber_o`=1 and `tx_enable_o`=0.
- R7: In QUIET, after UNJAB_CYCLES consecutive low samples following entry, the block returns to WATCH with `tx_enable_o`=1 and `jabber_o`=0. After UNJAB_CYCLES-1 such samples, `tx_enable_o` is still 0.
- R8: A high sample of `tx_active_i` in QUIET keeps the block in QUIET with `coll_req_o`=0. It restarts the recovery count, so UNJAB_CYCLES further low samples are needed.
- R9: After recovery the burst count starts from zero. ACT_CYCLES-1 high samples leave the driver enabled, and the next one trips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timebase clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_active_i | input | 1 | Transmit activity from the squelch path |
| tx_enable_o | output | 1 | Enable for the transmit driver |
| jabber_o | output | 1 | Jabber fault present (TRIPPED or QUIET) |
| coll_req_o | output | 1 | Request to the collision signalling logic (TRIPPED only) |

## Verification
The outputs are decoded directly from the state register. Each response is therefore due right after the rising edge that samples the deciding input value, with no extra pipeline delay:
- a trip follows the ACT_CYCLES-th high sample;
- release to QUIET follows the first low sample;
- re-enable follows the UNJAB_CYCLES-th low sample after entry to QUIET.

The bench drives `tx_active_i` and samples the outputs only at falling edges, so each check sees exactly the number of rising edges it has counted. Every boundary is probed one sample short of the limit and again at the limit.

// File: rtl/jab_pkg.sv
package jab_pkg;
    typedef enum logic [1:0] {
        JS_WATCH   = 2'd0,
        JS_TRIPPED = 2'd1,
        JS_QUIET   = 2'd2
    } jab_state_e;
endpackage

// File: rtl/jab_cycle_ctr.sv
// Run-length counter: cleared or advanced each cycle, flags the last count.
module jab_cycle_ctr #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign at_last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/jab_fsm.sv
module jab_fsm
    import jab_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_active,
    input  logic       act_last,
    input  logic       quiet_last,
    output jab_state_e state,
    output logic       act_clr,
    output logic       act_inc,
    output logic       quiet_clr,
    output logic       quiet_inc,
    output logic       tx_en,
    output logic       jab,
    output logic       coll
);
    jab_state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= JS_WATCH;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            JS_WATCH:   if (tx_active && act_last) state_nx = JS_TRIPPED;
            JS_TRIPPED: if (!tx_active)            state_nx = JS_QUIET;
            JS_QUIET:   if (!tx_active && quiet_last) state_nx = JS_WATCH;
            default:    state_nx = JS_WATCH;
        endcase
    end

    // outputs and counter controls
    always_comb begin
        tx_en     = 1'b0;
        jab       = 1'b0;
        coll      = 1'b0;
        act_clr   = 1'b1;
        act_inc   = 1'b0;
        quiet_clr = 1'b1;
        quiet_inc = 1'b0;
        unique case (state)
            JS_WATCH: begin
                tx_en   = 1'b1;
                act_clr = rst || !tx_active;
                act_inc = tx_active;
            end
            JS_TRIPPED: begin
                jab  = 1'b1;
                coll = 1'b1;
            end
            JS_QUIET: begin
                jab       = 1'b1;
                quiet_clr = rst || tx_active;
                quiet_inc = !tx_active;
            end
            default: begin
                tx_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/jab_watchdog.sv
module jab_watchdog
    import jab_pkg::*;
#(
    parameter int ACT_CYCLES   = 200000,
    parameter int UNJAB_CYCLES = 5000000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_active_i,
    output logic tx_enable_o,
    output logic jabber_o,
    output logic coll_req_o
);
    jab_state_e state;
    logic act_clr, act_inc, act_last;
    logic quiet_clr, quiet_inc, quiet_last;

    jab_cycle_ctr #(.LIMIT(ACT_CYCLES)) u_act_ctr (
        .clk     (clk),
        .clr     (act_clr),
        .inc     (act_inc),
        .at_last (act_last)
    );

    jab_cycle_ctr #(.LIMIT(UNJAB_CYCLES)) u_quiet_ctr (
        .clk     (clk),
        .clr     (quiet_clr),
        .inc     (quiet_inc),
        .at_last (quiet_last)
    );

    jab_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tx_active  (tx_active_i),
        .act_last   (act_last),
        .quiet_last (quiet_last),
        .state      (state),
        .act_clr    (act_clr),
        .act_inc    (act_inc),
        .quiet_clr  (quiet_clr),
        .quiet_inc  (quiet_inc),
        .tx_en      (tx_enable_o),
        .jab        (jabber_o),
        .coll       (coll_req_o)
    );
endmodule

// File: rtl/jab_watchdog_chk.sv
module jab_watchdog_chk
    import jab_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tx_active_i,
    input logic       tx_enable_o,
    input logic       jabber_o,
    input logic       coll_req_o,
    input jab_state_e state
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx_enable_o && !jabber_o && !coll_req_o));

    a_r2_trip_needs_activity: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_enable_o) |-> $past(tx_active_i));

    a_r3_idle_keeps_enable: assert property (@(posedge clk) disable iff (rst)
        (tx_enable_o && !tx_active_i) |=> tx_enable_o);

    a_r5_coll_held: assert property (@(posedge clk) disable iff (rst)
        (coll_req_o && tx_active_i) |=> coll_req_o);

    a_r6_release_to_quiet: assert property (@(posedge clk) disable iff (rst)
        (coll_req_o && !tx_active_i) |=> (!coll_req_o && jabber_o && !tx_enable_o));

    a_r7_reenable_from_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_enable_o) |-> $past(state == JS_QUIET && !tx_active_i));

    a_r8_quiet_restart: assert property (@(posedge clk) disable iff (rst)
        (state == JS_QUIET && tx_active_i) |=> (state == JS_QUIET && !coll_req_o));
endmodule

bind jab_watchdog jab_watchdog_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_active_i (tx_active_i),
    .tx_enable_o (tx_enable_o),
    .jabber_o    (jabber_o),
    .coll_req_o  (coll_req_o),
    .state       (state)
);

// File: tb/jab_watchdog_bench.sv
`timescale 1ns/1ps
module jab_watchdog_bench;
    localparam int ACT   = 8;
    localparam int UNJAB = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx  = 1'b0;
    logic en, jab, coll;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #10 clk = ~clk;

    jab_watchdog #(.ACT_CYCLES(ACT), .UNJAB_CYCLES(UNJAB)) u_jab_watchdog (
        .clk         (clk),
        .rst         (rst),
        .tx_active_i (tx),
        .tx_enable_o (en),
        .jabber_o    (jab),
        .coll_req_o  (coll)
    );

    // hold tx at v for n rising edges; returns at a falling edge
    task automatic drive(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            tx = v;
            @(negedge clk);
        end
    endtask

    // compare {en,jab,coll}
    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {en, jab, coll};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: en/jab/coll actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive(0, 3);
        chk("R1", 3'b100);
        rst = 1'b0;
        drive(0, 1);
        chk("R1", 3'b100);
    endtask

    task automatic t_short;
        drive(1, ACT - 1);
        chk("R3", 3'b100);
        drive(0, 1);
        chk("R3", 3'b100);
    endtask

    task automatic t_gap;
        drive(1, ACT - 1);
        drive(0, 1);
        drive(1, ACT - 1);
        chk("R4", 3'b100);
        drive(0, 1);
        chk("R4", 3'b100);
    endtask

    task automatic t_trip_and_recover;
        drive(1, ACT - 1);
        chk("R2", 3'b100);
        drive(1, 1);
        chk("R2", 3'b011);
        drive(1, 20);
        chk("R5", 3'b011);
        drive(0, 1);
        chk("R6", 3'b010);
        drive(0, UNJAB - 1);
        chk("R7", 3'b010);
        drive(0, 1);
        chk("R7", 3'b100);
    endtask

    task automatic t_restart;
        drive(1, ACT);
        chk("R2", 3'b011);
        drive(0, 1);
        drive(0, UNJAB - 2);
        chk("R8", 3'b010);
        drive(1, 1);
        chk("R8", 3'b010);
        drive(0, UNJAB - 1);
        chk("R8", 3'b010);
        drive(0, 1);
        chk("R8", 3'b100);
    endtask

    task automatic t_fresh;
        drive(1, ACT - 1);
        chk("R9", 3'b100);
        drive(1, 1);
        chk("R9", 3'b011);
        drive(0, 1 + UNJAB);
        chk("R9", 3'b100);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_short();
        t_gap();
        t_trip_and_recover();
        t_restart();
        t_fresh();
        // reset taken in the middle of a fault
        drive(1, ACT);
        rst = 1'b1;
        drive(1, 1);
        rst = 1'b0;
        tx  = 1'b0;
        chk("R1", 3'b100);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule